// File: doc/BRIEF.md
# Time-Varying Convolutional Parity Encoder (rate 1/2, systematic)

This block encodes a stream of information bits with a low-density parity-check convolutional code whose parity equations change periodically. Every accepted input bit produces one output pair: the same information bit plus one freshly computed parity bit. The parity bit is the XOR of the current information bit and a sparse, phase-dependent selection of the last `MEM` information bits and the last `MEM` parity bits. A phase counter that wraps every `PERIOD` accepted bits picks which selection applies, and both tap tables are parameters.

Frames are bounded by two markers. A start marker makes the encoder act as if all history were zero and the phase were 0 for that bit. The tail bits that bring the encoder back to rest are computed outside and fed in as ordinary information bits. On the bit carrying the end marker the block reports whether the whole history (information and parity) is zero after that bit, which confirms that the tail was correct.

Top module: `tvcc_sys_encoder`

## Requirements
- R1: One cycle after a cycle with `in_valid`=1, `out_valid`=1 and `out_sys` equals the `in_bit` of that cycle; after a cycle with `in_valid`=0, `out_valid`=0.
- R2: `out_par` equals the XOR of the set bits of `{info history, in_bit} & INFO_TAPS[p]` and `parity history & PAR_TAPS[p]`. Here p is the phase. Bit 0 of the information mask is the current bit and bit k is the information bit k accepted bits earlier. Bit j of the parity mask is the parity bit j+1 accepted bits earlier. Phase p owns bits `[p*(MEM+1) +: MEM+1]` of `INFO_TAPS` and bits `[p*MEM +: MEM]` of `PAR_TAPS`.
- R3: The phase advances by one on every accepted bit and wraps from `PERIOD-1` to 0.
- R4: A bit with `in_sof`=1 is encoded with all history taken as zero and phase 0. The following bit then uses phase 1.
- R5: Cycles with `in_valid`=0 leave history and phase unchanged.
- R6: `out_eof` is 1 exactly for the output of a bit accepted with `in_last`=1. `out_state_zero` is 1 only then, and only if all `2*MEM` history bits are zero after that bit.
- R7: After reset all outputs are 0, the history is zero and the phase is 0, so a first frame without a start marker is encoded from the zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An information bit is presented this cycle |
| in_sof | input | 1 | This bit opens a frame (zero state, phase 0) |
| in_last | input | 1 | This bit closes a frame |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Output pair valid |
| out_sys | output | 1 | Systematic bit (copy of input) |
| out_par | output | 1 | Parity bit |
| out_eof | output | 1 | Output belongs to the closing bit |
| out_state_zero | output | 1 | History is all zero after the closing bit |

## Verification
Random information bits are fed back to back and with random idle gaps. Back-to-back bits test the phase walk and its wrap, and gapped bits show whether idle cycles disturb the history or the phase. A start marker placed after a frame that left the history nonzero shows whether the preset really clears both histories. Frames are closed three ways: with arbitrary data, which should end nonzero, with a tail found by the bench's own search, and with all-zero content. Together these tell a correct zero-state report apart from a stuck or inverted one.

// File: rtl/tvcc_pkg.sv
package tvcc_pkg;
  typedef struct packed {
    logic vld;
    logic sys;
    logic par;
    logic eof;
    logic zero;
  } enc_out_t;

  function automatic int unsigned phase_width(input int unsigned period);
    return (period > 1) ? $clog2(period) : 1;
  endfunction
endpackage

// File: rtl/tvcc_phase.sv
module tvcc_phase #(
  parameter int unsigned PERIOD = 4,
  localparam int unsigned PW = tvcc_pkg::phase_width(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          restart,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_eff
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  assign phase_eff = restart ? '0 : phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= (phase_eff == LAST) ? '0 : phase_eff + 1'b1;
    end
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST); // R3
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart && phase_q == LAST) |=> phase_q == '0); // R3
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase_q)); // R5
endmodule

// File: rtl/tvcc_hist.sv
module tvcc_hist #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             clear,
  input  logic             din,
  output logic [DEPTH-1:0] q,
  output logic [DEPTH-1:0] q_eff
);
  assign q_eff = clear ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift) begin
      q <= {q_eff[DEPTH-2:0], din};
    end
  end

  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(q)); // R5
  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift |=> q[0] == $past(din)); // R2
endmodule

// File: rtl/tvcc_parity.sv
module tvcc_parity #(
  parameter int unsigned MEM    = 8,
  parameter int unsigned PERIOD = 4,
  parameter logic [PERIOD*(MEM+1)-1:0] INFO_TAPS = '0,
  parameter logic [PERIOD*MEM-1:0]     PAR_TAPS  = '0,
  localparam int unsigned PW = tvcc_pkg::phase_width(PERIOD)
) (
  input  logic [PW-1:0]  phase,
  input  logic           cur,
  input  logic [MEM-1:0] info_hist,
  input  logic [MEM-1:0] par_hist,
  output logic           par
);
  logic [PERIOD-1:0] cand;
  logic [MEM:0]      info_vec;

  assign info_vec = {info_hist, cur};

  for (genvar p = 0; p < PERIOD; p++) begin : g_phase
    localparam logic [MEM:0]   IMASK = INFO_TAPS[p*(MEM+1) +: MEM+1];
    localparam logic [MEM-1:0] PMASK = PAR_TAPS[p*MEM +: MEM];
    assign cand[p] = (^(info_vec & IMASK)) ^ (^(par_hist & PMASK));
  end

  always_comb begin
    par = 1'b0;
    for (int p = 0; p < PERIOD; p++) begin
      if (phase == PW'(p)) par = cand[p];
    end
  end
endmodule

// File: rtl/tvcc_sys_encoder.sv
module tvcc_sys_encoder #(
  parameter int unsigned MEM    = 8,
  parameter int unsigned PERIOD = 4,
  parameter logic [PERIOD*(MEM+1)-1:0] INFO_TAPS =
    {9'b001000001, 9'b100011001, 9'b010000011, 9'b000100101},
  parameter logic [PERIOD*MEM-1:0] PAR_TAPS =
    {8'b10000111, 8'b01010000, 8'b00100110, 8'b10001001}
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_last,
  input  logic in_bit,
  output logic out_valid,
  output logic out_sys,
  output logic out_par,
  output logic out_eof,
  output logic out_state_zero
);
  import tvcc_pkg::*;
  localparam int unsigned PW = phase_width(PERIOD);

  logic           clr;
  logic [PW-1:0]  phase_q, phase_eff;
  logic [MEM-1:0] ih_q, ih_eff, ph_q, ph_eff;
  logic           par_c;
  logic           next_zero;
  enc_out_t       oreg;

  assign clr = in_valid & in_sof;

  tvcc_phase #(.PERIOD(PERIOD)) u_phase (
    .clk(clk), .rst(rst), .adv(in_valid), .restart(clr),
    .phase_q(phase_q), .phase_eff(phase_eff)
  );

  tvcc_hist #(.DEPTH(MEM)) u_info_hist (
    .clk(clk), .rst(rst), .shift(in_valid), .clear(clr),
    .din(in_bit), .q(ih_q), .q_eff(ih_eff)
  );

  tvcc_hist #(.DEPTH(MEM)) u_par_hist (
    .clk(clk), .rst(rst), .shift(in_valid), .clear(clr),
    .din(par_c), .q(ph_q), .q_eff(ph_eff)
  );

  tvcc_parity #(
    .MEM(MEM), .PERIOD(PERIOD), .INFO_TAPS(INFO_TAPS), .PAR_TAPS(PAR_TAPS)
  ) u_parity (
    .phase(phase_eff), .cur(in_bit), .info_hist(ih_eff),
    .par_hist(ph_eff), .par(par_c)
  );

  assign next_zero = ({ih_eff[MEM-2:0], in_bit} == '0) &&
                     ({ph_eff[MEM-2:0], par_c} == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      oreg <= '0;
    end else if (in_valid) begin
      oreg.vld  <= 1'b1;
      oreg.sys  <= in_bit;
      oreg.par  <= par_c;
      oreg.eof  <= in_last;
      oreg.zero <= in_last & next_zero;
    end else begin
      oreg <= '0;
    end
  end

  assign out_valid      = oreg.vld;
  assign out_sys        = oreg.sys;
  assign out_par        = oreg.par;
  assign out_eof        = oreg.eof;
  assign out_state_zero = oreg.zero;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_SYS_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_sys == $past(in_bit)); // R1
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_EOF_MARKS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_eof == $past(in_last)); // R6
  AST_ZERO_ONLY_EOF: assert property (@(posedge clk) disable iff (rst)
    out_state_zero |-> out_eof); // R6
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ih_q[MEM-1:1] == '0 && ph_q[MEM-1:1] == '0 &&
             phase_q == PW'(1 % PERIOD))); // R4
endmodule

// File: tb/sim_tvcc_sys_encoder.sv
module sim_tvcc_sys_encoder;
  localparam int MEM = 8;
  localparam int PERIOD = 4;
  localparam logic [PERIOD*(MEM+1)-1:0] IT =
    {9'b001000001, 9'b100011001, 9'b010000011, 9'b000100101};
  localparam logic [PERIOD*MEM-1:0] PT =
    {8'b10000111, 8'b01010000, 8'b00100110, 8'b10001001};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_last = 0, in_bit = 0;
  logic out_valid, out_sys, out_par, out_eof, out_state_zero;

  always #4 clk = ~clk;

  tvcc_sys_encoder #(.MEM(MEM), .PERIOD(PERIOD), .INFO_TAPS(IT), .PAR_TAPS(PT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_bit(in_bit), .out_valid(out_valid),
    .out_sys(out_sys), .out_par(out_par), .out_eof(out_eof),
    .out_state_zero(out_state_zero)
  );

  int checks = 0, errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [MEM-1:0] m_ih = '0, m_ph = '0;
  int m_phase = 0;

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_par(input logic [MEM-1:0] ih, input logic [MEM-1:0] ph,
                                     input int p, input logic b);
    logic r;
    r = b & IT[p*(MEM+1)];
    for (int k = 1; k <= MEM; k++) r = r ^ (ih[k-1] & IT[p*(MEM+1)+k]);
    for (int j = 0; j < MEM; j++) r = r ^ (ph[j] & PT[p*MEM+j]);
    return r;
  endfunction

  function automatic bit tail_ok(input logic [MEM-1:0] ih0, input logic [MEM-1:0] ph0,
                                 input int phs0, input int len, input int v);
    logic [MEM-1:0] ih, ph;
    int phs;
    logic p, b;
    ih = ih0; ph = ph0; phs = phs0;
    for (int i = 0; i < len; i++) begin
      b = v[i];
      p = model_par(ih, ph, phs, b);
      ih = {ih[MEM-2:0], b};
      ph = {ph[MEM-2:0], p};
      phs = (phs + 1) % PERIOD;
    end
    return (ih == '0) && (ph == '0);
  endfunction

  // driver: called at a negedge, presents one bit and pushes its expectation
  task automatic send(input logic b, input logic sof, input logic last, input string tag);
    logic p, z;
    if (sof) begin m_ih = '0; m_ph = '0; m_phase = 0; end
    p = model_par(m_ih, m_ph, m_phase, b);
    m_ih = {m_ih[MEM-2:0], b};
    m_ph = {m_ph[MEM-2:0], p};
    m_phase = (m_phase + 1) % PERIOD;
    z = last && (m_ih == '0) && (m_ph == '0);
    exp_q.push_back({b, p, last, z});
    tag_q.push_back(tag);
    in_valid = 1; in_sof = sof; in_last = last; in_bit = b;
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_last = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R1 unexpected output", {out_sys, out_par, out_eof, out_state_zero}, 4'b0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_sys == e[3], "R1 systematic bit", {3'b0, out_sys}, {3'b0, e[3]});
        check(out_par == e[2], t, {3'b0, out_par}, {3'b0, e[2]});
        check(out_eof == e[1], "R6 end marker", {3'b0, out_eof}, {3'b0, e[1]});
        check(out_state_zero == e[0], "R6 zero-state report",
              {3'b0, out_state_zero}, {3'b0, e[0]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tl, tv;
    bit found;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7: reset state at the ports
    check({out_valid, out_sys, out_par, out_eof, out_state_zero} == 5'b0,
          "R7 reset outputs", {out_valid, out_par, out_eof, out_state_zero}, 4'b0);

    // Frame A: no start marker after reset (R7), back to back (R2, R3)
    for (int i = 0; i < 40; i++)
      send(1'($urandom), 1'b0, i == 39, "R2 R3 R7 parity back-to-back");
    // idle must output nothing (R1) and keep state (R5)
    idle(3);
    check(out_valid == 1'b0, "R1 idle gives no output", {3'b0, out_valid}, 4'b0);

    // Frame B: start marker over nonzero state (R4), random gaps (R5), searched tail
    for (int i = 0; i < 37; i++) begin
      send(1'($urandom), i == 0, 1'b0, "R4 R5 parity with gaps");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    found = 0; tl = 0; tv = 0;
    for (int l = 1; l <= 12 && !found; l++)
      for (int v = 0; v < (1 << l) && !found; v++)
        if (tail_ok(m_ih, m_ph, m_phase, l, v)) begin found = 1; tl = l; tv = v; end
    if (found) begin
      for (int i = 0; i < tl; i++) send(tv[i], 1'b0, i == tl - 1, "R6 R2 tail parity");
    end else begin
      send(1'b0, 1'b0, 1'b1, "R6 R2 untermined close");
    end
    idle(2);

    // Frame C: end nonzero, then restart with all-zero content
    for (int i = 0; i < 20; i++)
      send(1'($urandom), 1'b0, i == 19, "R2 R3 parity continuation");
    for (int i = 0; i < 20; i++)
      send(1'b0, i == 0, i == 19, "R4 R6 zero frame after preset");

    // Frame D: single one then zeros, with a gap right after the preset
    send(1'b1, 1'b1, 1'b0, "R4 impulse");
    idle(2);
    for (int i = 0; i < 12; i++)
      send(1'b0, 1'b0, i == 11, "R2 R5 impulse response");
    idle(3);
    check(exp_q.size() == 0, "R1 all outputs seen", 4'(exp_q.size()), 4'b0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule